// File: doc/BRIEF.md
# Rotating Slot Memory-Channel Scheduler

This block hands one shared external memory channel to a group of compute units in a fixed round-robin of equal time slots. Each slot lasts exactly as long as one block transfer (16 cycles by default). The unit that owns a slot receives its block and then computes while every other unit takes its own turn. With eight units, each unit therefore gets a compute window of seven transfers (112 cycles) between two of its own fetches. The schedule is fixed time-division and is driven only by slot position. It is not a request arbiter, and a slot whose owner cannot take data stays empty rather than being given to another unit.

A single-cycle start pulse clears all round counters and opens the first slot for unit 0. From then on, slots follow each other back to back in ascending unit order and wrap around. Each unit counts the completed transfers of its own slots. When it has counted the configured number of rounds (64 by default), it raises a one-cycle done pulse and is skipped for the rest of the job. Once every unit has finished, the rotation stops until the next start.

The channel side is a short handshake. A one-cycle burst-start marks the first cycle of a granted slot and comes with the index of the unit. The channel answers with a burst-done strobe, which credits the round.

Top module: `rotating_slot_sched`

## Requirements
- R1: While reset is high and in the cycle after it falls, `grant_o`, `burst_start_o`, `burst_unit_o`, `round_done_o` and `active_o` are all zero.
- R2: No grant is issued before the first start pulse, even with every ready input high. The clock edge that samples `start_i` opens a slot for unit 0, and `active_o` is high from the next cycle.
- R3: Each slot lasts SLOT_CYCLES cycles, and slot owners run 0, 1, ..., NUM_UNITS-1 and then wrap to 0. A granted slot shows exactly one bit `grant_o[u]` for all of its cycles. `burst_unit_o` equals u while a grant is shown and is 0 otherwise. `burst_start_o` is high only in the first cycle of a granted slot.
- R4: The owner's `ready_i` bit is sampled only on the edge that opens its slot. If that bit is low, the whole slot stays idle with no grant, and the start times of later slots do not move.
- R5: A unit's round count goes up by one on the first cycle of its granted slot in which `burst_done_i` is high, including the slot's last cycle. Further `burst_done_i` strobes in the same slot, and strobes while no grant is shown, change no count.
- R6: When a unit's count reaches JOB_ROUNDS, `round_done_o[u]` is high for exactly the one cycle after the crediting strobe. The unit receives no later grant until the next start.
- R7: Two cycles after the strobe that finishes the last unit, `active_o` falls and grants and burst starts stay low until the next start.
- R8: A start pulse during a job clears every round count and finished mark and opens a slot for unit 0 on the same edge.
- R9: With all units always ready and each transfer ending in the last cycle of its slot, the last done pulse appears JOB_ROUNDS x NUM_UNITS x SLOT_CYCLES cycles after the start edge. This is 64 x 128 cycles with the default values.
- R10: When `start_i` and `burst_done_i` are high in the same cycle, the restart wins and no round is credited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that clears all counters and starts the rotation at unit 0 |
| ready_i | input | NUM_UNITS | Per-unit request to be served in its next own slot |
| burst_done_i | input | 1 | Strobe from the memory channel that the current transfer has completed |
| grant_o | output | NUM_UNITS | One-hot owner of the current granted slot |
| burst_start_o | output | 1 | High in the first cycle of a granted slot |
| burst_unit_o | output | $clog2(NUM_UNITS) | Index of the granted unit, 0 when no grant is shown |
| round_done_o | output | NUM_UNITS | One-cycle pulse when a unit completes its last round |
| active_o | output | 1 | Rotation is running |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that reset is held for at least one edge before any start. They place no limit on `ready_i` or `burst_done_i`, and those may toggle freely. The stimulus keeps every start to one cycle and issues some starts in the middle of a slot. It drives ready with a level that is inverted away from the slot-opening edge, so only the sampled value can matter. It also sends duplicate and stray transfer strobes so that the crediting rules are exercised.

// File: rtl/rot_sched_pkg.sv
package rot_sched_pkg;

    // Rotation state of the slot timer.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Event raised on the edge that opens a new slot.
    typedef struct packed {
        logic open;     // a slot begins at the coming edge
        logic restart;  // the coming edge is a start edge
    } slot_event_t;

    // True when a phase counter sits on the last cycle of a slot.
    function automatic logic phase_is_last(int unsigned phase, int unsigned len);
        return phase == (len - 1);
    endfunction

    // Index width for a count of items (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rs_slot_timer.sv
module rs_slot_timer
    import rot_sched_pkg::*;
#(
    parameter int NUM_UNITS   = 8,
    parameter int SLOT_CYCLES = 16,
    localparam int IDX_W      = idx_width(NUM_UNITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic                 all_fin_i,
    output logic                 active_o,
    output logic                 halt_o,
    output logic [IDX_W-1:0]     slot_idx_o,
    output logic [IDX_W-1:0]     open_idx_o,
    output slot_event_t          ev_o
);
    localparam int CNT_W = idx_width(SLOT_CYCLES);

    run_state_e          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    phase_q;
    logic [IDX_W-1:0]    idx_next;
    logic                last;

    assign last     = phase_is_last(32'(phase_q), SLOT_CYCLES);
    assign idx_next = (idx_q == IDX_W'(NUM_UNITS - 1)) ? '0 : idx_q + 1'b1;

    // Stop once every unit has finished its job.
    assign halt_o   = (state_q == ST_RUN) && all_fin_i;

    always_comb begin
        ev_o.restart = start_i;
        ev_o.open    = start_i || ((state_q == ST_RUN) && last && !all_fin_i);
        open_idx_o   = start_i ? '0 : idx_next;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            phase_q <= '0;
        end else if (start_i) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
            phase_q <= '0;
        end else if (halt_o) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            phase_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (last) begin
                phase_q <= '0;
                idx_q   <= idx_next;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign active_o   = (state_q == ST_RUN);
    assign slot_idx_o = idx_q;

endmodule

// File: rtl/rs_grant_gen.sv
module rs_grant_gen
    import rot_sched_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int IDX_W    = idx_width(NUM_UNITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  slot_event_t          ev_i,
    input  logic                 halt_i,
    input  logic [IDX_W-1:0]     open_idx_i,
    input  logic [IDX_W-1:0]     owner_i,
    input  logic [NUM_UNITS-1:0] ready_i,
    input  logic [NUM_UNITS-1:0] fin_i,
    output logic                 granted_o,
    output logic [NUM_UNITS-1:0] grant_o,
    output logic                 burst_start_o,
    output logic [IDX_W-1:0]     burst_unit_o
);
    logic grant_q;
    logic bstart_q;
    logic take;

    // A start clears every finished mark, so only ready matters then.
    always_comb begin
        take = ready_i[open_idx_i] && (ev_i.restart || !fin_i[open_idx_i]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            grant_q  <= 1'b0;
            bstart_q <= 1'b0;
        end else if (ev_i.open) begin
            grant_q  <= take;
            bstart_q <= take;
        end else begin
            bstart_q <= 1'b0;
            if (halt_i) begin
                grant_q <= 1'b0;
            end
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_grant
        assign grant_o[u] = grant_q && (owner_i == IDX_W'(u));
    end

    assign granted_o     = grant_q;
    assign burst_start_o = bstart_q;
    assign burst_unit_o  = grant_q ? owner_i : '0;

endmodule

// File: rtl/rs_round_bank.sv
module rs_round_bank
    import rot_sched_pkg::*;
#(
    parameter int NUM_UNITS  = 8,
    parameter int JOB_ROUNDS = 64,
    localparam int IDX_W     = idx_width(NUM_UNITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  slot_event_t          ev_i,
    input  logic                 granted_i,
    input  logic [IDX_W-1:0]     owner_i,
    input  logic                 burst_done_i,
    output logic [NUM_UNITS-1:0] fin_o,
    output logic [NUM_UNITS-1:0] done_pulse_o
);
    localparam int RND_W = idx_width(JOB_ROUNDS + 1);

    logic credited_q;
    logic hit;

    // First completion strobe in a granted slot; a start edge never credits.
    assign hit = granted_i && burst_done_i && !credited_q && !ev_i.restart;

    always_ff @(posedge clk_i) begin
        if (rst_i || ev_i.restart) begin
            credited_q <= 1'b0;
        end else if (ev_i.open) begin
            credited_q <= 1'b0;
        end else if (hit) begin
            credited_q <= 1'b1;
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic [RND_W-1:0] rounds_q;
        logic             fin_q;
        logic             pulse_q;
        logic             mine;

        assign mine = hit && (owner_i == IDX_W'(u)) && !fin_q;

        always_ff @(posedge clk_i) begin
            if (rst_i || ev_i.restart) begin
                rounds_q <= '0;
                fin_q    <= 1'b0;
                pulse_q  <= 1'b0;
            end else begin
                pulse_q <= 1'b0;
                if (mine) begin
                    rounds_q <= rounds_q + 1'b1;
                    if (rounds_q == RND_W'(JOB_ROUNDS - 1)) begin
                        fin_q   <= 1'b1;
                        pulse_q <= 1'b1;
                    end
                end
            end
        end

        assign fin_o[u]        = fin_q;
        assign done_pulse_o[u] = pulse_q;
    end

endmodule

// File: rtl/rotating_slot_sched.sv
module rotating_slot_sched
    import rot_sched_pkg::*;
#(
    parameter int NUM_UNITS   = 8,
    parameter int SLOT_CYCLES = 16,
    parameter int JOB_ROUNDS  = 64,
    localparam int IDX_W      = idx_width(NUM_UNITS)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 start_i,
    input  logic [NUM_UNITS-1:0] ready_i,
    input  logic                 burst_done_i,
    output logic [NUM_UNITS-1:0] grant_o,
    output logic                 burst_start_o,
    output logic [IDX_W-1:0]     burst_unit_o,
    output logic [NUM_UNITS-1:0] round_done_o,
    output logic                 active_o
);
    slot_event_t          ev;
    logic                 halt;
    logic                 granted;
    logic                 all_fin;
    logic [IDX_W-1:0]     slot_idx;
    logic [IDX_W-1:0]     open_idx;
    logic [NUM_UNITS-1:0] fin;

    assign all_fin = &fin;

    rs_slot_timer #(
        .NUM_UNITS   (NUM_UNITS),
        .SLOT_CYCLES (SLOT_CYCLES)
    ) timer_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .all_fin_i  (all_fin),
        .active_o   (active_o),
        .halt_o     (halt),
        .slot_idx_o (slot_idx),
        .open_idx_o (open_idx),
        .ev_o       (ev)
    );

    rs_grant_gen #(
        .NUM_UNITS (NUM_UNITS)
    ) grant_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .ev_i          (ev),
        .halt_i        (halt),
        .open_idx_i    (open_idx),
        .owner_i       (slot_idx),
        .ready_i       (ready_i),
        .fin_i         (fin),
        .granted_o     (granted),
        .grant_o       (grant_o),
        .burst_start_o (burst_start_o),
        .burst_unit_o  (burst_unit_o)
    );

    rs_round_bank #(
        .NUM_UNITS  (NUM_UNITS),
        .JOB_ROUNDS (JOB_ROUNDS)
    ) rounds_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ev_i         (ev),
        .granted_i    (granted),
        .owner_i      (slot_idx),
        .burst_done_i (burst_done_i),
        .fin_o        (fin),
        .done_pulse_o (round_done_o)
    );

endmodule

// File: rtl/rs_sched_checker.sv
module rs_sched_checker
    import rot_sched_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int IDX_W    = idx_width(NUM_UNITS)
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 start_i,
    input logic [NUM_UNITS-1:0] grant_o,
    input logic                 burst_start_o,
    input logic [IDX_W-1:0]     burst_unit_o,
    input logic [NUM_UNITS-1:0] round_done_o,
    input logic                 active_o
);
    assert_grant_onehot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(grant_o));

    assert_start_has_owner_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        burst_start_o |-> (grant_o != '0) && grant_o[burst_unit_o]);

    assert_grant_changes_at_slot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$stable(grant_o) && (grant_o != '0)) |-> burst_start_o);

    assert_start_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        burst_start_o |=> !burst_start_o);

    assert_first_slot_unit0_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> ((grant_o == '0) || grant_o[0]) && active_o);

    assert_single_done_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(round_done_o));

    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_o |-> (grant_o == '0) && !burst_start_o);

endmodule

bind rotating_slot_sched rs_sched_checker #(
    .NUM_UNITS (NUM_UNITS)
) chk_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .start_i       (start_i),
    .grant_o       (grant_o),
    .burst_start_o (burst_start_o),
    .burst_unit_o  (burst_unit_o),
    .round_done_o  (round_done_o),
    .active_o      (active_o)
);

// File: tb/rotating_slot_sched_tb_top.sv
module rotating_slot_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 4;
    localparam int SLOT   = 4;
    localparam int ROUNDS = 3;
    localparam int IW     = 2;

    logic          clk = 1'b0;
    logic          rst_i;
    logic          start_i;
    logic [N-1:0]  ready_i;
    logic          burst_done_i;
    logic [N-1:0]  grant_o;
    logic          burst_start_o;
    logic [IW-1:0] burst_unit_o;
    logic [N-1:0]  round_done_o;
    logic          active_o;

    int tests = 0;
    int fails = 0;
    bit all_over = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rotating_slot_sched #(
        .NUM_UNITS   (N),
        .SLOT_CYCLES (SLOT),
        .JOB_ROUNDS  (ROUNDS)
    ) dut_i (
        .clk_i         (clk),
        .rst_i         (rst_i),
        .start_i       (start_i),
        .ready_i       (ready_i),
        .burst_done_i  (burst_done_i),
        .grant_o       (grant_o),
        .burst_start_o (burst_start_o),
        .burst_unit_o  (burst_unit_o),
        .round_done_o  (round_done_o),
        .active_o      (active_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Ready pattern per slot number: mode 0 always ready, mode 1 skips some.
    function automatic logic [N-1:0] pat(input int mode, input int k);
        logic [N-1:0] p;
        for (int u = 0; u < N; u++) begin
            p[u] = (mode == 0) ? 1'b1 : (((k + u) % 3) != 0);
        end
        return p;
    endfunction

    // Runs one job from a start pulse issued at the current negedge.
    task automatic run_job(input int mode, input int dph, input bit dbl, input bit stray,
                           input bit done_at_start, input int limit,
                           output int done_seen, output int last_pulse);
        int           rounds_m [N];
        bit           fin_m    [N];
        bit           granted_m;
        bit           credited_m;
        logic [N-1:0] exp_done;
        logic [N-1:0] next_done;
        int           stop_at;
        done_seen  = 0;
        last_pulse = -1;
        for (int u = 0; u < N; u++) begin
            rounds_m[u] = 0;
            fin_m[u]    = 0;
        end
        granted_m  = 0;
        credited_m = 0;
        exp_done   = '0;
        stop_at    = -1;
        start_i      = 1'b1;
        ready_i      = pat(mode, 0);
        burst_done_i = done_at_start;
        for (int c = 0; c < limit; c++) begin
            int           k;
            int           ph;
            int           u;
            logic [N-1:0] eg;
            bit           ebs;
            int           eu;
            bit           eact;
            bit           dn;
            @(negedge clk);
            start_i = 1'b0;
            k  = c / SLOT;
            ph = c % SLOT;
            u  = k % N;
            if (stop_at >= 0 && c >= stop_at) begin
                granted_m = 0;
                eact      = 0;
            end else begin
                if (ph == 0) begin
                    granted_m  = pat(mode, k)[u] && !fin_m[u];
                    credited_m = 0;
                end
                eact = 1;
            end
            eg  = granted_m ? (N'(1) << u) : '0;
            ebs = granted_m && (ph == 0);
            eu  = granted_m ? u : 0;
            check(grant_o == eg, "R4", "grant vector", int'(grant_o), int'(eg));
            check(burst_start_o == ebs, "R3", "burst start", int'(burst_start_o), int'(ebs));
            check(int'(burst_unit_o) == eu, "R3", "burst unit", int'(burst_unit_o), eu);
            check(active_o == eact, "R7", "active", int'(active_o), int'(eact));
            check(round_done_o == exp_done, "R6", "done pulse", int'(round_done_o), int'(exp_done));
            if (round_done_o != '0) begin
                done_seen  += $countones(round_done_o);
                last_pulse = c;
            end
            // Channel model for this cycle.
            dn = ((ph == dph) && (granted_m || stray)) ||
                 (dbl && granted_m && (ph == dph + 1));
            burst_done_i = dn;
            next_done = '0;
            if (granted_m && dn && !credited_m) begin
                credited_m = 1;
                rounds_m[u]++;
                if (rounds_m[u] == ROUNDS) begin
                    bit all;
                    fin_m[u]     = 1;
                    next_done[u] = 1'b1;
                    all = 1;
                    for (int v = 0; v < N; v++) all &= fin_m[v];
                    if (all) stop_at = c + 2;
                end
            end
            exp_done = next_done;
            // Ready counts only on the slot-opening edge; elsewhere it is inverted.
            if (mode == 1 && ph != SLOT - 1) ready_i = ~pat(mode, k + 1);
            else                             ready_i = pat(mode, k + 1);
            if (stop_at >= 0 && c >= stop_at + 2) break;
        end
        burst_done_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!all_over) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int seen;
        int lastp;
        rst_i = 1'b1;
        start_i = 1'b0;
        ready_i = '1;
        burst_done_i = 1'b0;
        repeat (3) @(negedge clk);
        check(grant_o == '0 && !burst_start_o && burst_unit_o == '0, "R1", "reset outputs",
              int'(grant_o), 0);
        check(round_done_o == '0 && !active_o, "R1", "reset done/active", int'(active_o), 0);
        rst_i = 1'b0;
        @(negedge clk);
        check(grant_o == '0 && !active_o, "R1", "after reset release", int'(grant_o), 0);

        // R2: nothing before a start even with every unit ready.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(grant_o == '0 && !burst_start_o && !active_o, "R2", "idle before start",
                  int'(grant_o), 0);
        end

        // Full job, all ready, transfer ends in the last slot cycle: R9.
        run_job(0, SLOT - 1, 0, 0, 0, 400, seen, lastp);
        check(seen == N, "R6", "done pulses in job", seen, N);
        check(lastp == ROUNDS * N * SLOT, "R9", "last done cycle", lastp, ROUNDS * N * SLOT);

        // Skipped slots, early double strobes and stray strobes: R4, R5.
        run_job(1, 1, 1, 1, 0, 600, seen, lastp);
        check(seen == N, "R5", "done pulses with skips", seen, N);

        // Restart in mid-job with a strobe in the start cycle: R8, R10.
        run_job(0, SLOT - 1, 0, 0, 0, 30, seen, lastp);
        run_job(0, SLOT - 1, 0, 0, 1, 400, seen, lastp);
        check(seen == N, "R8", "done pulses after restart", seen, N);
        check(lastp == ROUNDS * N * SLOT, "R10", "no credit at start edge", lastp,
              ROUNDS * N * SLOT);

        // Skips with the strobe in the final slot cycle and stray strobes.
        run_job(1, SLOT - 1, 0, 1, 0, 600, seen, lastp);
        check(seen == N, "R5", "done pulses late strobe", seen, N);

        repeat (4) @(negedge clk);
        check(grant_o == '0 && !active_o, "R7", "stays idle after job", int'(grant_o), 0);

        all_over = 1;
        summary();
        $finish;
    end

endmodule